// File: doc/BRIEF.md
# Host Parallel Channel Access Port

This block gives a host processor direct byte access to the channels of a time-division multiplexed frame. The host places a channel number on its address lines. In a single strobed bus cycle it either deposits a byte for that channel or collects the byte that the switch delivered for it. Host-written bytes are offered to the switching fabric as source channels. Bytes that the fabric writes into destination channels come back to the host on reads. Both directions pass through a two-stage holding arrangement: the visible stage is loaded from the collecting stage in one step at every frame boundary, so every byte crosses with exactly one frame of delay.

A free-running frame timer produces the boundary. At each boundary the block raises an interrupt, and the host clears it with a write-one-to-clear on a status register. The block also drives a guard flag for a few clocks on either side of the boundary, while the stages are being swapped. During the guard the block refuses host channel writes and records the attempt in a sticky error bit. Host channel reads made during the guard keep the previously returned byte, so the host never sees a byte that is half way through the swap. Unused register addresses and unused status bits read as zero.

Top module: `host_parallel_access`

## Requirements
- R1: A byte that the host writes to channel c outside the guard appears on `fab_src_data` when `fab_src_ch` = c only after the next frame boundary edge. Until that edge the fabric sees the byte that was loaded at the previous boundary.
- R2: A byte that the fabric writes with `fab_dst_we` into channel c is returned by host reads of channel c only after the next frame boundary edge. Before that edge, reads return the byte loaded at the previous boundary.
- R3: A read cycle (`host_stb`=1, `host_wr_n`=1) updates `host_rdata` and sets `host_rvalid` for the single following cycle. A write cycle, or a cycle with no strobe, leaves `host_rvalid` low in the following cycle.
- R4: The frame counter starts at 0 on reset and a boundary edge occurs at every clock edge where the counter equals FRAME_LEN-1. Each boundary edge sets `host_irq`. The interrupt then stays high until a host write to the status address (address MSB = 1, low bits = 0) carries data bit 0 = 1. A new boundary in the same cycle as a clear wins.
- R5: A boundary edge that finds the interrupt still pending, with no clear of bit 0 in that cycle, sets the overrun flag, status bit 1. The flag stays set until it is cleared by writing 1 to status bit 1.
- R6: `host_guard` is high whenever the counter value p satisfies p >= FRAME_LEN-GUARD or p < GUARD. This covers GUARD clocks before each boundary edge and GUARD clocks after it. Status bit 3 reads this live flag.
- R7: A host channel write (address MSB = 0) in a guard cycle changes no channel byte. It sets the sticky guard-write error, status bit 2, which is cleared by writing 1 to bit 2.
- R8: A host channel read in a guard cycle still pulses `host_rvalid`, but `host_rdata` keeps the byte of the previous read.
- R9: Register addresses other than the status address read 0, and writes to them change nothing. Status bits 7 down to 4 read 0.
- R10: After reset all channel bytes are 0, the status bits are 0, and `host_rdata`, `host_rvalid` and `host_irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| host_stb | input | 1 | Host cycle strobe, one cycle per access |
| host_wr_n | input | 1 | Cycle kind: 0 write, 1 read |
| host_addr | input | CH_W+1 | MSB 0: channel number in low bits; MSB 1: register space |
| host_wdata | input | DATA_W | Host write byte |
| host_rdata | output | DATA_W | Host read byte, valid with host_rvalid |
| host_rvalid | output | 1 | Read data valid, one cycle after a read strobe |
| host_irq | output | 1 | Frame boundary interrupt, pending until cleared |
| host_guard | output | 1 | Unsafe window around the frame boundary |
| fab_src_ch | input | CH_W | Fabric source channel select |
| fab_src_data | output | DATA_W | Host-supplied byte of the selected source channel |
| fab_dst_we | input | 1 | Fabric destination byte write enable |
| fab_dst_ch | input | CH_W | Fabric destination channel |
| fab_dst_data | input | DATA_W | Fabric destination byte |

## Verification
The bench writes bytes and checks that they stay invisible until exactly one boundary has passed. A design that copied the stages on the wrong counter value, or wrote straight through, would expose the byte early or late. It places host writes and reads in the last clocks before a boundary and in the first clocks after it. This catches a guard window that is off by one, which would let a write land or let a read return the freshly swapped byte. It lets boundaries pass without a clear and clears status at chosen moments. A design that dropped the overrun or let a clear on one bit wipe another would show a wrong status byte. Reserved addresses are written and read back, to catch a decoder that aliases them onto the status register.

// File: rtl/hpa_pkg.sv
// Package for the host parallel access port.
// Holds the status bit positions and the status record shared by the host
// interface, the top level and the checker.
package hpa_pkg;

    localparam int ST_PEND_BIT  = 0;
    localparam int ST_OVR_BIT   = 1;
    localparam int ST_GERR_BIT  = 2;
    localparam int ST_GUARD_BIT = 3;
    localparam int ST_USED_BITS = 4;

    typedef struct packed {
        logic gerr;
        logic ovr;
        logic pend;
    } hpa_status_t;

endpackage

// File: rtl/hpa_frame_timer.sv
// Frame timer.
// Counts clocks within a frame of FRAME_LEN clocks. It flags the boundary edge
// (the last count, after which the counter wraps to zero) and the guard window
// of GUARD clocks on each side of that edge.
// Assumes FRAME_LEN > 2*GUARD + 2 so that a safe part of the frame exists.
module hpa_frame_timer #(
    parameter int FRAME_LEN = 512,
    parameter int GUARD     = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic frame_edge,
    output logic guard
);
    localparam int CNT_W = (FRAME_LEN > 1) ? $clog2(FRAME_LEN) : 1;
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(FRAME_LEN - 1);
    localparam logic [CNT_W-1:0] PRE_CNT  = CNT_W'(FRAME_LEN - GUARD);
    localparam logic [CNT_W-1:0] POST_CNT = CNT_W'(GUARD);

    logic [CNT_W-1:0] cnt_q;

    // Advance the in-frame position and wrap at the frame end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (frame_edge) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Decode the boundary edge and the window around it.
    always_comb begin
        frame_edge = (cnt_q == LAST_CNT);
        guard      = (cnt_q >= PRE_CNT) || (cnt_q < POST_CNT);
    end

endmodule

// File: rtl/hpa_chan_buffer.sv
// Two-stage channel buffer.
// One byte per channel in a collecting stage and one in a visible stage.
// Writes land in the collecting stage. On xfer the whole collecting stage is
// copied to the visible stage in one clock; a write in the same clock lands
// in the collecting stage only. The visible stage is read combinationally.
// Assumes NUM_CH is a power of two.
module hpa_chan_buffer #(
    parameter int NUM_CH = 128,
    parameter int DATA_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [$clog2(NUM_CH)-1:0] wr_ch,
    input  logic [DATA_W-1:0]         wr_data,
    input  logic                      xfer,
    input  logic [$clog2(NUM_CH)-1:0] rd_ch,
    output logic [DATA_W-1:0]         rd_data
);
    localparam int CH_W = $clog2(NUM_CH);

    logic [DATA_W-1:0] vis_arr [NUM_CH];

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic [DATA_W-1:0] coll_q;
        logic [DATA_W-1:0] vis_q;

        // Keep this channel's collecting byte and its visible copy.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                coll_q <= '0;
                vis_q  <= '0;
            end else begin
                if (xfer) begin
                    vis_q <= coll_q;
                end
                if (wr_en && (wr_ch == CH_W'(g))) begin
                    coll_q <= wr_data;
                end
            end
        end

        assign vis_arr[g] = vis_q;
    end

    assign rd_data = vis_arr[rd_ch];

endmodule

// File: rtl/hpa_host_if.sv
// Host-side decode and status.
// Splits the address into channel space (MSB 0) and register space (MSB 1).
// Gates channel writes with the guard flag and keeps the interrupt, overrun
// and guard-write error bits (each write-one-to-clear, a new set wins).
// Registers read data one clock after a read strobe; a guarded channel read
// keeps the previous byte.
// Assumes DATA_W >= 4 so that all status bits fit in the data byte.
module hpa_host_if
    import hpa_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stb,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              guard,
    input  logic              frame_edge,
    input  logic [DATA_W-1:0] chan_rdata,
    output logic              chan_we,
    output logic [DATA_W-1:0] chan_wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid,
    output hpa_status_t       status
);
    localparam int CH_W = ADDR_W - 1;
    localparam int PAD_W = DATA_W - ST_USED_BITS;

    logic              is_reg;
    logic              stat_sel;
    logic              rd_cyc;
    logic              wr_cyc;
    logic              guard_wr;
    logic              clr_pend;
    logic              clr_ovr;
    logic              clr_gerr;
    logic [DATA_W-1:0] stat_word;
    hpa_status_t       st_q;

    // Decode the cycle kind, target space and clear requests.
    always_comb begin
        is_reg   = addr[ADDR_W-1];
        stat_sel = is_reg && (addr[CH_W-1:0] == '0);
        rd_cyc   = stb && wr_n;
        wr_cyc   = stb && !wr_n;
        chan_we  = wr_cyc && !is_reg && !guard;
        guard_wr = wr_cyc && !is_reg && guard;
        clr_pend = wr_cyc && stat_sel && wdata[ST_PEND_BIT];
        clr_ovr  = wr_cyc && stat_sel && wdata[ST_OVR_BIT];
        clr_gerr = wr_cyc && stat_sel && wdata[ST_GERR_BIT];
    end

    assign chan_wdata = wdata;

    // Assemble the readable status byte with zero-filled upper bits.
    always_comb begin
        stat_word = {{PAD_W{1'b0}}, guard, st_q.gerr, st_q.ovr, st_q.pend};
    end

    // Keep the interrupt, overrun and guard-write error bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q.pend <= frame_edge || (st_q.pend && !clr_pend);
            st_q.ovr  <= (frame_edge && st_q.pend && !clr_pend)
                         || (st_q.ovr && !clr_ovr);
            st_q.gerr <= guard_wr || (st_q.gerr && !clr_gerr);
        end
    end

    // Capture read data one clock after a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= rd_cyc;
            if (rd_cyc) begin
                if (is_reg) begin
                    rdata <= stat_sel ? stat_word : '0;
                end else if (!guard) begin
                    rdata <= chan_rdata;
                end
            end
        end
    end

    assign status = st_q;

endmodule

// File: rtl/host_parallel_access.sv
// Host parallel channel access port, top level.
// Joins the frame timer, the host decode and two channel buffers: the
// source buffer (host writes, fabric reads) and the destination buffer
// (fabric writes, host reads). Both buffers swap stages on the boundary edge.
// Assumes NUM_CH is a power of two and FRAME_LEN > 2*GUARD + 2.
module host_parallel_access
    import hpa_pkg::*;
#(
    parameter int NUM_CH    = 128,
    parameter int DATA_W    = 8,
    parameter int FRAME_LEN = 512,
    parameter int GUARD     = 4,
    parameter int CH_W      = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_stb,
    input  logic              host_wr_n,
    input  logic [CH_W:0]     host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_rvalid,
    output logic              host_irq,
    output logic              host_guard,
    input  logic [CH_W-1:0]   fab_src_ch,
    output logic [DATA_W-1:0] fab_src_data,
    input  logic              fab_dst_we,
    input  logic [CH_W-1:0]   fab_dst_ch,
    input  logic [DATA_W-1:0] fab_dst_data
);
    localparam int ADDR_W = CH_W + 1;

    logic              frame_edge;
    logic              guard;
    logic              chan_we;
    logic [DATA_W-1:0] chan_wdata;
    logic [DATA_W-1:0] dst_rdata;
    hpa_status_t       st;

    hpa_frame_timer #(
        .FRAME_LEN (FRAME_LEN),
        .GUARD     (GUARD)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_edge (frame_edge),
        .guard      (guard)
    );

    hpa_host_if #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_host (
        .clk        (clk),
        .rst_n      (rst_n),
        .stb        (host_stb),
        .wr_n       (host_wr_n),
        .addr       (host_addr),
        .wdata      (host_wdata),
        .guard      (guard),
        .frame_edge (frame_edge),
        .chan_rdata (dst_rdata),
        .chan_we    (chan_we),
        .chan_wdata (chan_wdata),
        .rdata      (host_rdata),
        .rvalid     (host_rvalid),
        .status     (st)
    );

    hpa_chan_buffer #(
        .NUM_CH (NUM_CH),
        .DATA_W (DATA_W)
    ) u_src (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (chan_we),
        .wr_ch   (host_addr[CH_W-1:0]),
        .wr_data (chan_wdata),
        .xfer    (frame_edge),
        .rd_ch   (fab_src_ch),
        .rd_data (fab_src_data)
    );

    hpa_chan_buffer #(
        .NUM_CH (NUM_CH),
        .DATA_W (DATA_W)
    ) u_dst (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (fab_dst_we),
        .wr_ch   (fab_dst_ch),
        .wr_data (fab_dst_data),
        .xfer    (frame_edge),
        .rd_ch   (host_addr[CH_W-1:0]),
        .rd_data (dst_rdata)
    );

    assign host_irq   = st.pend;
    assign host_guard = guard;

endmodule

// File: rtl/hpa_checker.sv
// Property checker for the host parallel access port, bound to the top.
// Relates host strobes, the boundary edge, the guard flag and the status
// bits over time.
module hpa_checker #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int CH_W   = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_stb,
    input logic              host_wr_n,
    input logic [ADDR_W-1:0] host_addr,
    input logic              wdata_b0,
    input logic [DATA_W-1:0] host_rdata,
    input logic              host_rvalid,
    input logic              host_irq,
    input logic              host_guard,
    input logic [CH_W-1:0]   fab_src_ch,
    input logic [DATA_W-1:0] fab_src_data,
    input logic              frame_edge,
    input logic              st_ovr,
    input logic              st_gerr
);
    localparam logic [ADDR_W-1:0] STAT_ADDR = {1'b1, {(ADDR_W-1){1'b0}}};

    logic clr_pend_wr;
    logic chan_wr;
    logic chan_rd;

    // Name the host cycle kinds used by the properties.
    always_comb begin
        clr_pend_wr = host_stb && !host_wr_n && (host_addr == STAT_ADDR) && wdata_b0;
        chan_wr     = host_stb && !host_wr_n && !host_addr[ADDR_W-1];
        chan_rd     = host_stb && host_wr_n && !host_addr[ADDR_W-1];
    end

    a_r3_rvalid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        (host_stb && host_wr_n) |=> host_rvalid);

    a_r3_no_rvalid_otherwise: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_stb && host_wr_n) |=> !host_rvalid);

    a_r4_irq_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
        frame_edge |=> host_irq);

    a_r4_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (host_irq && !clr_pend_wr) |=> host_irq);

    a_r5_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_edge && host_irq && !clr_pend_wr) |=> st_ovr);

    a_r6_guard_at_edge: assert property (@(posedge clk) disable iff (!rst_n)
        frame_edge |-> host_guard);

    a_r6_guard_after_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $past(frame_edge) |-> host_guard);

    a_r7_guard_write_flagged: assert property (@(posedge clk) disable iff (!rst_n)
        (host_guard && chan_wr) |=> st_gerr);

    a_r8_guard_read_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (host_guard && chan_rd) |=> $stable(host_rdata));

    a_r1_src_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(fab_src_ch) && !$past(frame_edge)) |-> $stable(fab_src_data));

endmodule

bind host_parallel_access hpa_checker #(
    .ADDR_W (CH_W + 1),
    .DATA_W (DATA_W),
    .CH_W   (CH_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_stb     (host_stb),
    .host_wr_n    (host_wr_n),
    .host_addr    (host_addr),
    .wdata_b0     (host_wdata[0]),
    .host_rdata   (host_rdata),
    .host_rvalid  (host_rvalid),
    .host_irq     (host_irq),
    .host_guard   (host_guard),
    .fab_src_ch   (fab_src_ch),
    .fab_src_data (fab_src_data),
    .frame_edge   (frame_edge),
    .st_ovr       (st.ovr),
    .st_gerr      (st.gerr)
);

// File: tb/tb_host_parallel_access.sv
module tb_host_parallel_access;
    localparam int NUM_CH = 128;
    localparam int DATA_W = 8;
    localparam int FL     = 64;
    localparam int G      = 4;
    localparam int CH_W   = 7;
    localparam logic [7:0] STAT = 8'h80;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              host_stb = 1'b0;
    logic              host_wr_n = 1'b1;
    logic [CH_W:0]     host_addr = '0;
    logic [DATA_W-1:0] host_wdata = '0;
    logic [DATA_W-1:0] host_rdata;
    logic              host_rvalid;
    logic              host_irq;
    logic              host_guard;
    logic [CH_W-1:0]   fab_src_ch = '0;
    logic [DATA_W-1:0] fab_src_data;
    logic              fab_dst_we = 1'b0;
    logic [CH_W-1:0]   fab_dst_ch = '0;
    logic [DATA_W-1:0] fab_dst_data = '0;

    always #2 clk = ~clk;

    host_parallel_access #(
        .NUM_CH    (NUM_CH),
        .DATA_W    (DATA_W),
        .FRAME_LEN (FL),
        .GUARD     (G)
    ) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .host_stb     (host_stb),
        .host_wr_n    (host_wr_n),
        .host_addr    (host_addr),
        .host_wdata   (host_wdata),
        .host_rdata   (host_rdata),
        .host_rvalid  (host_rvalid),
        .host_irq     (host_irq),
        .host_guard   (host_guard),
        .fab_src_ch   (fab_src_ch),
        .fab_src_data (fab_src_data),
        .fab_dst_we   (fab_dst_we),
        .fab_dst_ch   (fab_dst_ch),
        .fab_dst_data (fab_dst_data)
    );

    int errors = 0;
    int checks = 0;

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model, advanced on every rising edge.
    int mk = 0;
    int hs [NUM_CH];
    int os [NUM_CH];
    int hd [NUM_CH];
    int vd [NUM_CH];
    int m_pend = 0, m_ovr = 0, m_gerr = 0, m_rdata = 0, m_rvalid = 0;
    bit seen = 1'b0;

    function automatic int gfun(input int k);
        int p;
        p = k % FL;
        return ((p >= FL - G) || (p < G)) ? 1 : 0;
    endfunction

    always @(posedge clk) begin : model
        int g, b, isreg, ch, clr;
        seen = 1'b1;
        if (!rst_n) begin
            mk = 0;
            for (int i = 0; i < NUM_CH; i++) begin
                hs[i] = 0; os[i] = 0; hd[i] = 0; vd[i] = 0;
            end
            m_pend = 0; m_ovr = 0; m_gerr = 0; m_rdata = 0; m_rvalid = 0;
        end else begin
            g     = gfun(mk);
            b     = ((mk % FL) == FL - 1) ? 1 : 0;
            isreg = int'(host_addr[7]);
            ch    = int'(host_addr[6:0]);
            clr   = (host_stb && !host_wr_n && host_addr == STAT) ? int'(host_wdata) : 0;
            if (host_stb && host_wr_n) begin
                if (isreg != 0)
                    m_rdata = (ch == 0) ? ((g << 3) | (m_gerr << 2) | (m_ovr << 1) | m_pend) : 0;
                else if (g == 0)
                    m_rdata = vd[ch];
            end
            m_rvalid = (host_stb && host_wr_n) ? 1 : 0;
            m_ovr  = ((b != 0) && (m_pend != 0) && ((clr & 1) == 0)) ? 1
                     : ((m_ovr != 0) && ((clr & 2) == 0)) ? 1 : 0;
            m_pend = (b != 0) ? 1 : ((m_pend != 0) && ((clr & 1) == 0)) ? 1 : 0;
            m_gerr = (host_stb && !host_wr_n && isreg == 0 && g != 0) ? 1
                     : ((m_gerr != 0) && ((clr & 4) == 0)) ? 1 : 0;
            if (b != 0) begin
                for (int i = 0; i < NUM_CH; i++) begin
                    os[i] = hs[i];
                    vd[i] = hd[i];
                end
            end
            if (host_stb && !host_wr_n && isreg == 0 && g == 0) hs[ch] = int'(host_wdata);
            if (fab_dst_we) hd[fab_dst_ch] = int'(fab_dst_data);
            mk++;
        end
    end

    // Compare every clock, away from the rising edge.
    always @(negedge clk) begin
        if (seen) begin
            check("R3/R2/R8/R9/R10 host_rdata vs model", int'(host_rdata), m_rdata);
            check("R3 host_rvalid vs model", int'(host_rvalid), m_rvalid);
            check("R4/R10 host_irq vs model", int'(host_irq), m_pend);
            check("R6 host_guard vs model", int'(host_guard), gfun(mk));
            check("R1 fab_src_data vs model", int'(fab_src_data), os[fab_src_ch]);
        end
    end

    task automatic wait_phase(input int p);
        forever begin
            @(posedge clk); #1;
            if ((mk % FL) == p) break;
        end
    endtask

    task automatic hwrite(input logic [7:0] a, input logic [7:0] d);
        host_stb = 1'b1; host_wr_n = 1'b0; host_addr = a; host_wdata = d;
        @(posedge clk); #1;
        host_stb = 1'b0; host_wr_n = 1'b1;
    endtask

    task automatic hread(input logic [7:0] a, output int d);
        host_stb = 1'b1; host_wr_n = 1'b1; host_addr = a;
        @(posedge clk); #1;
        host_stb = 1'b0;
        d = int'(host_rdata);
    endtask

    task automatic fwrite(input logic [6:0] c, input logic [7:0] d);
        fab_dst_we = 1'b1; fab_dst_ch = c; fab_dst_data = d;
        @(posedge clk); #1;
        fab_dst_we = 1'b0;
    endtask

    initial begin : main
        int r;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;

        // R10: reset state
        wait_phase(8);
        check("R10 irq after reset", int'(host_irq), 0);
        hread(STAT, r);
        check("R10 status after reset", r, 0);
        check("R3 rvalid after read", int'(host_rvalid), 1);
        hread(8'h05, r);
        check("R10 channel 5 after reset", r, 0);

        // R1: host bytes reach the fabric one boundary later
        fab_src_ch = 7'd3;
        wait_phase(10);
        hwrite(8'h03, 8'hA5);
        check("R3 no rvalid after write", int'(host_rvalid), 0);
        hwrite(8'h7F, 8'h5A);
        #1 check("R1 source before boundary", int'(fab_src_data), 0);
        wait_phase(1);
        check("R1 source ch3 after boundary", int'(fab_src_data), 8'hA5);
        fab_src_ch = 7'd127;
        #1 check("R1 source ch127 after boundary", int'(fab_src_data), 8'h5A);
        check("R4 irq after boundary", int'(host_irq), 1);

        // R4: clear the interrupt
        wait_phase(10);
        hwrite(STAT, 8'h01);
        check("R4 irq cleared", int'(host_irq), 0);

        // R2: fabric bytes reach the host one boundary later
        fwrite(7'd9, 8'hC3);
        hread(8'h09, r);
        check("R2 destination before boundary", r, 0);
        wait_phase(8);
        hread(8'h09, r);
        check("R2 destination after boundary", r, 8'hC3);

        // R5: second boundary without clear sets overrun
        wait_phase(8);
        hread(STAT, r);
        check("R5 status shows overrun", r, 8'h03);
        hwrite(STAT, 8'h03);
        hread(STAT, r);
        check("R5 status cleared", r, 0);

        // R7: guarded writes are dropped and flagged
        wait_phase(FL - 2);
        hwrite(8'h03, 8'hFF);
        wait_phase(2);
        hwrite(8'h7F, 8'h77);
        wait_phase(8);
        hread(STAT, r);
        check("R7 guard error and pending", r, 8'h05);
        fab_src_ch = 7'd3;
        #1 check("R7 ch3 unchanged", int'(fab_src_data), 8'hA5);
        fab_src_ch = 7'd127;
        #1 check("R7 ch127 unchanged", int'(fab_src_data), 8'h5A);
        hwrite(STAT, 8'h07);
        hread(STAT, r);
        check("R7 error cleared", r, 0);

        // R8: guarded reads hold the previous byte
        wait_phase(10);
        hread(8'h09, r);
        check("R8 setup read ch9", r, 8'hC3);
        fwrite(7'd9, 8'h3C);
        hread(8'h04, r);
        check("R8 setup read ch4", r, 0);
        wait_phase(1);
        hread(8'h09, r);
        check("R8 guarded read holds", r, 0);
        check("R8 guarded read rvalid", int'(host_rvalid), 1);
        wait_phase(8);
        hread(8'h09, r);
        check("R8 read after guard", r, 8'h3C);

        // R9: reserved registers and bits
        hwrite(8'h85, 8'hFF);
        hread(8'h85, r);
        check("R9 reserved reads zero", r, 0);
        hread(8'hFF, r);
        check("R9 top reserved reads zero", r, 0);
        hwrite(8'h81, 8'hFF);
        hread(STAT, r);
        check("R9 reserved write keeps pending", r & 1, 1);
        check("R9 upper status bits zero", r >> 4, 0);

        // R6: guard window edges
        wait_phase(FL - G - 1);
        check("R6 guard low before window", int'(host_guard), 0);
        wait_phase(FL - G);
        check("R6 guard high at window start", int'(host_guard), 1);
        wait_phase(G - 1);
        check("R6 guard high at window end", int'(host_guard), 1);
        wait_phase(G);
        check("R6 guard low after window", int'(host_guard), 0);
        wait_phase(FL - 1);
        hread(STAT, r);
        check("R6 status guard bit", (r >> 3) & 1, 1);

        repeat (3) @(posedge clk);
        #1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule